// File: doc/BRIEF.md
# Codec Host Bus Port

This block is the host-facing side of an audio codec. A host reaches it over an 8-bit data bus with active-low read, write and select strobes. Through this bus the host can read and write four directly addressed bytes, pull captured samples out of a capture queue, and push playback samples into a playback queue. The converter side of the codec fills the capture queue and drains the playback queue through simple one-cycle push and pop ports.

Register traffic is qualified by the select line. Sample traffic is qualified by a per-channel active-low acknowledge, and select is ignored for it. Each channel raises an active-high request that follows its queue level: capture asks while data is waiting, and playback asks while there is room. The strobes are brought into the internal clock domain before they act. Every register write, queue push and queue pop happens once, on the release edge of its strobe. The block also drives the enable and direction pins of an external bus transceiver straight from the strobes.

Top module: `audio_bus_port`

## Requirements
- R1: After reset, capReq is 0, playReq is 1, capUnderrun and playOverrun are 0, xcvrEnN and xcvrDir are 1, dataOe is 0, and all four registers read back 0x00.
- R2: capReq is 1 exactly when the capture queue holds at least one byte. It stays 1 until the queue has been drained empty.
- R3: playReq is 1 exactly when the playback queue is not full. It drops when the 16th byte is stored.
- R4: When wrN is released while csN is low and playAckN is high, dataIn is stored into the register selected by addr (2 bits, four registers). While rdN and csN are low with capAckN high, dataOut shows the selected register, and the read has no side effect. A write with csN high and no acknowledge low changes no register.
- R5: Releasing rdN while capAckN is low pops the capture queue exactly once, whatever csN is. While the strobe is low, dataOut shows the oldest queued byte.
- R6: Releasing wrN while playAckN is low pushes dataIn into the playback queue exactly once, whatever csN is. No register is written by that cycle.
- R7: xcvrEnN is 0 exactly when (rdN or wrN is low) and (csN, capAckN or playAckN is low). Otherwise it is 1.
- R8: xcvrDir is 0 (codec to host) exactly when rdN is low and (csN, capAckN or playAckN is low). Otherwise it is 1 (host to codec).
- R9: dataOe is 1 only while rdN is low together with csN low or capAckN low. A read qualified only by playAckN does not drive the bus.
- R10: A sample read from an empty capture queue returns the last byte popped. It sets capUnderrun, which stays 1 until reset.
- R11: A sample write to a full playback queue is dropped and the stored bytes are untouched. It sets playOverrun, which stays 1 until reset.
- R12: A converter push into the capture queue in the same cycle as a host pop takes effect together with the pop. A converter push into a full capture queue is dropped.
- R13: Both queues are 16 bytes deep and return bytes in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset |
| rdN | input | 1 | Host read strobe, active low |
| wrN | input | 1 | Host write strobe, active low |
| csN | input | 1 | Register select, active low |
| capAckN | input | 1 | Capture sample acknowledge, active low |
| playAckN | input | 1 | Playback sample acknowledge, active low |
| addr | input | 2 | Register index |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data |
| dataOe | output | 1 | Drive enable for dataOut |
| xcvrEnN | output | 1 | External transceiver enable, active low |
| xcvrDir | output | 1 | Transceiver direction, 1 host-to-codec |
| capReq | output | 1 | Capture service request |
| playReq | output | 1 | Playback service request |
| capPushValid | input | 1 | Converter pushes a capture byte |
| capPushData | input | 8 | Capture byte from converter |
| playPopReq | input | 1 | Converter takes a playback byte |
| playPopData | output | 8 | Oldest playback byte |
| capUnderrun | output | 1 | Sticky: capture read while empty |
| playOverrun | output | 1 | Sticky: playback write while full |

## Verification
Two operations can hit the capture queue in the same clock edge: the converter pushing a byte, and the synchronized release of a host read popping one. The bench holds capPushValid high over a window of nine edges and releases a sample read inside that window. The pop, which lands two edges after the release, therefore always meets a push. The result is judged by draining the queue through host reads: the count of bytes before capReq falls must equal the starting level, minus one, plus nine, and the bytes must come out in order.

// File: rtl/abp_pkg.sv
package abp_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 2;

  // one snapshot of the host pins, carried through the synchronizer
  typedef struct packed {
    logic              rdN;
    logic              wrN;
    logic              csN;
    logic              capAckN;
    logic              playAckN;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pinSet_t;

  // single-cycle commands from control to datapath
  typedef struct packed {
    logic              regWr;
    logic [ADDR_W-1:0] regIdx;
    logic              capPop;
    logic              playPush;
    logic [DATA_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/abp_fifo.sv
module abp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    level;
  logic             doPush, doPop;

  assign empty  = (level == '0);
  assign full   = (level == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/abp_ctrl.sv
module abp_ctrl
  import abp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  pinSet_t pinsIn,
  output strobe_t strb
);
  localparam int NST = SYNC_STAGES + 1;
  localparam pinSet_t IDLE = '{rdN: 1'b1, wrN: 1'b1, csN: 1'b1, capAckN: 1'b1,
                               playAckN: 1'b1, addr: '0, data: '0};

  pinSet_t pipe [NST];
  pinSet_t cur, prev;
  logic    rdRise, wrRise;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        pipe[g] <= IDLE;
      else if (g == 0)  pipe[g] <= pinsIn;
      else              pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
    end
  end

  assign cur    = pipe[NST-2];
  assign prev   = pipe[NST-1];
  assign rdRise = !prev.rdN && cur.rdN;
  assign wrRise = !prev.wrN && cur.wrN;

  // qualifiers are taken from the snapshot in which the strobe was still low
  always_comb begin
    strb.capPop   = rdRise && !prev.capAckN;
    strb.playPush = wrRise && !prev.playAckN;
    strb.regWr    = wrRise && prev.playAckN && !prev.csN;
    strb.regIdx   = prev.addr;
    strb.wrData   = prev.data;
  end
endmodule

// File: rtl/abp_data.sv
module abp_data
  import abp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              capAckN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              capPushValid,
  input  logic [DATA_W-1:0] capPushData,
  input  logic              playPopReq,
  output logic [DATA_W-1:0] playPopData,
  output logic [DATA_W-1:0] dataOut,
  output logic              capReq,
  output logic              playReq,
  output logic              capUnderrun,
  output logic              playOverrun
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] capHead, lastCap;
  logic              capEmpty, capFull, playEmpty, playFull;

  abp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_capQ (
    .clk(clk), .rstN(rstN),
    .push(capPushValid), .pushData(capPushData),
    .pop(strb.capPop), .head(capHead),
    .empty(capEmpty), .full(capFull)
  );

  abp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_playQ (
    .clk(clk), .rstN(rstN),
    .push(strb.playPush), .pushData(strb.wrData),
    .pop(playPopReq), .head(playPopData),
    .empty(playEmpty), .full(playFull)
  );

  assign capReq  = !capEmpty;
  assign playReq = !playFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
      lastCap     <= '0;
      capUnderrun <= 1'b0;
      playOverrun <= 1'b0;
    end else begin
      if (strb.regWr) regFile[strb.regIdx] <= strb.wrData;
      if (strb.capPop) begin
        if (capEmpty) capUnderrun <= 1'b1;
        else          lastCap     <= capHead;
      end
      if (strb.playPush && playFull) playOverrun <= 1'b1;
    end
  end

  // full flag of the capture queue is only needed for drop behaviour inside the queue
  logic unusedFlags;
  assign unusedFlags = capFull ^ playEmpty;

  always_comb begin
    if (!capAckN) dataOut = capEmpty ? lastCap : capHead;
    else          dataOut = regFile[addr];
  end
endmodule

// File: rtl/audio_bus_port.sv
module audio_bus_port
  import abp_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              csN,
  input  logic              capAckN,
  input  logic              playAckN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              xcvrEnN,
  output logic              xcvrDir,
  output logic              capReq,
  output logic              playReq,
  input  logic              capPushValid,
  input  logic [DATA_W-1:0] capPushData,
  input  logic              playPopReq,
  output logic [DATA_W-1:0] playPopData,
  output logic              capUnderrun,
  output logic              playOverrun
);
  pinSet_t pins;
  strobe_t strb;
  logic    anyQual, anyStrobe;

  assign pins = '{rdN: rdN, wrN: wrN, csN: csN, capAckN: capAckN,
                  playAckN: playAckN, addr: addr, data: dataIn};

  assign anyQual   = !csN || !capAckN || !playAckN;
  assign anyStrobe = !rdN || !wrN;
  assign xcvrEnN   = !(anyStrobe && anyQual);
  assign xcvrDir   = !(!rdN && anyQual);
  assign dataOe    = !rdN && (!csN || !capAckN);

  abp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinsIn(pins), .strb(strb)
  );

  abp_data #(.DEPTH(FIFO_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .capAckN(capAckN), .addr(addr),
    .capPushValid(capPushValid), .capPushData(capPushData),
    .playPopReq(playPopReq), .playPopData(playPopData),
    .dataOut(dataOut), .capReq(capReq), .playReq(playReq),
    .capUnderrun(capUnderrun), .playOverrun(playOverrun)
  );
endmodule

// File: rtl/audio_bus_port_chk.sv
module audio_bus_port_chk
  import abp_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    rdN,
  input logic    capReq,
  input logic    playReq,
  input logic    capPushValid,
  input logic    capUnderrun,
  input logic    playOverrun,
  input logic    dataOe,
  input logic    xcvrDir,
  input strobe_t strb
);
  // R2
  cap_req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capReq) |-> $past(capPushValid));

  // R3
  play_req_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(playReq) |-> $past(strb.playPush));

  // R10
  underrun_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capUnderrun) |-> ($past(strb.capPop) && !$past(capReq)));

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    capUnderrun |=> capUnderrun);

  // R11
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(playOverrun) |-> ($past(strb.playPush) && !$past(playReq)));

  // R9
  data_oe_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!xcvrDir && !rdN));
endmodule

bind audio_bus_port audio_bus_port_chk u_chk (
  .clk(clk), .rstN(rstN), .rdN(rdN), .capReq(capReq), .playReq(playReq),
  .capPushValid(capPushValid), .capUnderrun(capUnderrun),
  .playOverrun(playOverrun), .dataOe(dataOe), .xcvrDir(xcvrDir), .strb(strb)
);

// File: tb/audio_bus_port_bench.sv
`timescale 1ns/1ps
module audio_bus_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdN = 1'b1, wrN = 1'b1, csN = 1'b1, capAckN = 1'b1, playAckN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] dataIn = '0, capPushData = '0;
  logic       capPushValid = 1'b0, playPopReq = 1'b0;
  logic [7:0] dataOut, playPopData;
  logic       dataOe, xcvrEnN, xcvrDir, capReq, playReq, capUnderrun, playOverrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_bus_port u_audio_bus_port (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .csN(csN),
    .capAckN(capAckN), .playAckN(playAckN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .xcvrEnN(xcvrEnN), .xcvrDir(xcvrDir),
    .capReq(capReq), .playReq(playReq), .capPushValid(capPushValid),
    .capPushData(capPushData), .playPopReq(playPopReq), .playPopData(playPopData),
    .capUnderrun(capUnderrun), .playOverrun(playOverrun)
  );

  // {rdN, wrN, csN, capAckN, playAckN, xcvrEnN, xcvrDir, dataOe}
  localparam logic [7:0] VEC [10] = '{
    8'b11111_110, 8'b01011_001, 8'b10011_010, 8'b01111_110, 8'b10111_110,
    8'b01101_001, 8'b10110_010, 8'b01110_000, 8'b10101_010, 8'b11100_110
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rdN = 1; wrN = 1; csN = 1; capAckN = 1; playAckN = 1;
    capPushValid = 0; playPopReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pioWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    addr = a; dataIn = d; csN = !sel; wrN = 0;
    repeat (3) @(negedge clk);
    wrN = 1; csN = 1;
    settle();
  endtask

  task automatic pioRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; csN = 0; rdN = 0;
    repeat (2) @(negedge clk);
    #1 d = dataOut;
    @(negedge clk);
    rdN = 1; csN = 1;
    settle();
  endtask

  task automatic dmaRead(input logic useCs, output logic [7:0] d);
    @(negedge clk);
    capAckN = 0; csN = !useCs; rdN = 0;
    repeat (2) @(negedge clk);
    #1 d = dataOut;
    @(negedge clk);
    rdN = 1; capAckN = 1; csN = 1;
    settle();
  endtask

  task automatic dmaWrite(input logic useCs, input logic [7:0] d);
    @(negedge clk);
    playAckN = 0; csN = !useCs; dataIn = d; addr = 2'd0; wrN = 0;
    repeat (3) @(negedge clk);
    wrN = 1; playAckN = 1; csN = 1;
    settle();
  endtask

  task automatic capPush(input logic [7:0] d);
    @(negedge clk);
    capPushValid = 1; capPushData = d;
    @(negedge clk);
    capPushValid = 0;
  endtask

  task automatic playPop(output logic [7:0] d);
    @(negedge clk);
    d = playPopData; playPopReq = 1;
    @(negedge clk);
    playPopReq = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %h expected %h", 8'h0, 8'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    doReset();

    // R1 reset state
    #1;
    chk("R1 capReq", {7'b0, capReq}, 8'h0);
    chk("R1 playReq", {7'b0, playReq}, 8'h1);
    chk("R1 flags", {6'b0, capUnderrun, playOverrun}, 8'h0);
    chk("R1 xcvr idle", {5'b0, xcvrEnN, xcvrDir, dataOe}, 8'b110);
    for (int i = 0; i < 4; i++) begin
      pioRead(2'(i), d);
      chk("R1 register zero", d, 8'h00);
    end

    // R7 R8 R9 transceiver vector table
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {rdN, wrN, csN, capAckN, playAckN} = VEC[i][7:3];
      #1;
      chk("R7 xcvrEnN", {7'b0, xcvrEnN}, {7'b0, VEC[i][2]});
      chk("R8 xcvrDir", {7'b0, xcvrDir}, {7'b0, VEC[i][1]});
      chk("R9 dataOe", {7'b0, dataOe}, {7'b0, VEC[i][0]});
      @(negedge clk);
      rdN = 1; wrN = 1; csN = 1; capAckN = 1; playAckN = 1;
      settle();
    end
    doReset();

    // R4 register write and read back
    for (int i = 0; i < 4; i++) pioWrite(2'(i), 8'h10 + 8'(i * 17), 1'b1);
    for (int i = 0; i < 4; i++) begin
      pioRead(2'(i), d);
      chk("R4 register readback", d, 8'h10 + 8'(i * 17));
    end
    pioWrite(2'd1, 8'hEE, 1'b0);
    pioRead(2'd1, d);
    chk("R4 write without select ignored", d, 8'h21);

    // R6 sample write with select low: pushes, register 0 untouched
    dmaWrite(1'b1, 8'hC3);
    pioRead(2'd0, d);
    chk("R6 register untouched", d, 8'h10);
    playPop(d);
    chk("R6 pushed byte", d, 8'hC3);

    // R2 R5 R13 capture path
    capPush(8'hA1); capPush(8'hA2); capPush(8'hA3);
    #1 chk("R2 capReq with data", {7'b0, capReq}, 8'h1);
    dmaRead(1'b0, d); chk("R5 first byte", d, 8'hA1);
    dmaRead(1'b1, d); chk("R5 select ignored, second byte", d, 8'hA2);
    #1 chk("R2 capReq still high", {7'b0, capReq}, 8'h1);
    dmaRead(1'b0, d); chk("R13 third byte", d, 8'hA3);
    #1 chk("R2 capReq after drain", {7'b0, capReq}, 8'h0);

    // R10 underrun
    chk("R10 flag clear before", {7'b0, capUnderrun}, 8'h0);
    dmaRead(1'b0, d);
    chk("R10 last byte returned", d, 8'hA3);
    chk("R10 underrun set", {7'b0, capUnderrun}, 8'h1);
    repeat (4) @(negedge clk);
    chk("R10 underrun sticky", {7'b0, capUnderrun}, 8'h1);

    // R3 R11 playback fill and overrun
    for (int i = 0; i < 16; i++) begin
      #1 chk("R3 playReq before full", {7'b0, playReq}, 8'h1);
      dmaWrite(1'b0, 8'(i));
    end
    chk("R3 playReq when full", {7'b0, playReq}, 8'h0);
    dmaWrite(1'b0, 8'h99);
    chk("R11 overrun set", {7'b0, playOverrun}, 8'h1);
    for (int i = 0; i < 16; i++) begin
      playPop(d);
      chk("R11 R13 playback order", d, 8'(i));
      if (i == 0) chk("R3 playReq after pop", {7'b0, playReq}, 8'h1);
    end
    chk("R11 overrun sticky", {7'b0, playOverrun}, 8'h1);

    // R12 R13 capture full drop
    for (int i = 0; i < 17; i++) capPush(8'h40 + 8'(i));
    begin
      int n = 0;
      logic [7:0] last = 8'h00;
      while (capReq && n < 40) begin
        dmaRead(1'b0, d);
        if (n == 0) chk("R13 capture first", d, 8'h40);
        last = d;
        n++;
      end
      chk("R13 capture depth", 8'(n), 8'd16);
      chk("R12 push when full dropped", last, 8'h4F);
    end

    // R12 converter push and host pop in the same cycle
    capPush(8'hB1); capPush(8'hB2); capPush(8'hB3);
    @(negedge clk);
    capPushValid = 1; capPushData = 8'h55;
    capAckN = 0; rdN = 0;
    repeat (2) @(negedge clk);
    #1 d = dataOut;
    chk("R12 concurrent read data", d, 8'hB1);
    @(negedge clk);
    rdN = 1; capAckN = 1;
    repeat (6) @(negedge clk);
    capPushValid = 0;
    settle();
    begin
      int n = 0;
      while (capReq && n < 40) begin
        dmaRead(1'b0, d);
        if (n == 0) chk("R12 next after concurrent", d, 8'hB2);
        if (n == 2) chk("R12 pushed byte", d, 8'h55);
        n++;
      end
      chk("R12 level after concurrent", 8'(n), 8'd11);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule